// File: doc/BRIEF.md
# Indirect Table Window Port

This block gives software a narrow, two-register window onto a large set of internal lookup tables. A pointer register holds which table to reach, which entry inside it, and whether the entry number should step forward after each access. A second register, the data window, is the doorway: every read or write of the window lands on the entry the pointer currently names.

Tables differ in depth, so each table select has its own power-of-two index mask. An entry number that overshoots the selected table is folded back into range by that mask instead of being refused, and a one-cycle flag reports that the fold happened. With stepping enabled, every window access (read or write) moves the entry number on by one, wrapping inside the selected table, and the new value is stored back into the pointer. That lets software stream a whole table through the window. Six of the tables hold real storage. The others are accepted as valid selects but keep no data. Select codes outside the known set make window accesses inert.

Top module: `ind_table_port`

## Requirements
- R1: The pointer register keeps only three fields: entry number in bits [9:0], table select in bits [19:16] and the step-enable bit in bit 31. A pointer write stores these fields. A pointer read returns them with every other bit zero.
- R2: Table selects and their index masks are: 0→7, 1→7, 2→31, 3→31, 4→63, 5→7, 6→255, 7→255, 8→511, 9→63, 10→63, 11→15, 12→255, 13→3.
- R3: A window access reaches entry (entry number AND mask) of the selected table. An out-of-range entry number aliases onto that entry without being rejected.
- R4: With step enabled, any window access to a known select (0..13) sets the pointer entry number to ((entry AND mask) + 1) AND mask. With step disabled, the entry number is left unchanged.
- R5: Tables 0, 1, 8, 11, 12 and 13 keep written data, which a later window read of the same entry returns.
- R6: Tables 2, 3, 4, 5, 6, 7, 9 and 10 discard window writes. A window read of any of them returns zero.
- R7: With select 14 or 15, a window access does nothing. A read returns zero, no write strobe fires and the pointer stays unchanged.
- R8: Bit t of `tbl_wstrobe` is high for exactly the one cycle after a window write to known table t. All strobe bits are low at every other time.
- R9: `idx_clip_pulse` is high for exactly the one cycle after a window access to a known select whose entry number had bits outside the mask.
- R10: Every read request gives `rsp_valid` with its data in the cycle after the request.
- R11: After reset the pointer is zero and `rsp_valid`, `tbl_wstrobe` and `idx_clip_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A register access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_to_data | input | 1 | 1 = data window, 0 = pointer register |
| req_wdata | input | 64 | Write value |
| rsp_valid | output | 1 | Read data is valid this cycle |
| rsp_rdata | output | 64 | Read data |
| tbl_wstrobe | output | 14 | Per-table write pulse |
| idx_clip_pulse | output | 1 | Entry number was folded by the table mask |

## Verification
All results are registered once, so the read data, the strobe bit, the clip flag and the updated pointer are all due one clock after the request edge. The bench drives each request on a falling edge and removes it on the next falling edge. Strobe and clip are checked at that second falling edge, where the response queue is also popped. Pointer updates are checked by a later pointer read, which lands in the same one-cycle slot. The expected pointer, entry aliasing and table contents come from a separate model built from the mask list and the storage list.

// File: rtl/ind_tbl_pkg.sv
package ind_tbl_pkg;

    localparam int DATA_W     = 64;
    localparam int IDX_W      = 10;
    localparam int IDX_LSB    = 0;
    localparam int SEL_W      = 4;
    localparam int SEL_LSB    = 16;
    localparam int STEP_BIT   = 31;
    localparam int NUM_TBL    = 14;
    localparam int NUM_STORED = 6;

    typedef enum logic [SEL_W-1:0] {
        TBL_LINK_LIST    = 4'd0,
        TBL_LINE_IRQ     = 4'd1,
        TBL_CACHE_CAM    = 4'd2,
        TBL_REMAP_BASE   = 4'd3,
        TBL_REQ_CAM      = 4'd4,
        TBL_MSG_ROUTE    = 4'd5,
        TBL_ERRSTATE_A   = 4'd6,
        TBL_ERRSTATE_B   = 4'd7,
        TBL_XLATE_VALID  = 4'd8,
        TBL_XLATE_CAM    = 4'd9,
        TBL_XLATE_DATA   = 4'd10,
        TBL_WIN64_BAR    = 4'd11,
        TBL_WIN32_DOMAIN = 4'd12,
        TBL_ERR_VECTOR   = 4'd13
    } tbl_id_e;

    typedef struct packed {
        logic             step;
        logic [SEL_W-1:0] sel;
        logic [IDX_W-1:0] idx;
    } ptr_reg_t;

    // Index mask per table select; unknown selects yield zero.
    function automatic logic [IDX_W-1:0] idx_mask(input logic [SEL_W-1:0] s);
        case (s)
            TBL_LINK_LIST, TBL_LINE_IRQ, TBL_MSG_ROUTE:  return IDX_W'(7);
            TBL_CACHE_CAM, TBL_REMAP_BASE:               return IDX_W'(31);
            TBL_REQ_CAM, TBL_XLATE_CAM, TBL_XLATE_DATA:  return IDX_W'(63);
            TBL_ERRSTATE_A, TBL_ERRSTATE_B,
            TBL_WIN32_DOMAIN:                            return IDX_W'(255);
            TBL_XLATE_VALID:                             return IDX_W'(511);
            TBL_WIN64_BAR:                               return IDX_W'(15);
            TBL_ERR_VECTOR:                              return IDX_W'(3);
            default:                                     return '0;
        endcase
    endfunction

    function automatic logic sel_known(input logic [SEL_W-1:0] s);
        return int'(s) < NUM_TBL;
    endfunction

    function automatic logic has_store(input logic [SEL_W-1:0] s);
        case (s)
            TBL_LINK_LIST, TBL_LINE_IRQ, TBL_XLATE_VALID,
            TBL_WIN64_BAR, TBL_WIN32_DOMAIN, TBL_ERR_VECTOR: return 1'b1;
            default:                                         return 1'b0;
        endcase
    endfunction

    // Slot k of the storage bank -> table select it serves.
    function automatic int stored_sel(input int k);
        case (k)
            0:       return int'(TBL_LINK_LIST);
            1:       return int'(TBL_LINE_IRQ);
            2:       return int'(TBL_XLATE_VALID);
            3:       return int'(TBL_WIN64_BAR);
            4:       return int'(TBL_WIN32_DOMAIN);
            default: return int'(TBL_ERR_VECTOR);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] ptr_pack(input ptr_reg_t p);
        logic [DATA_W-1:0] w;
        w = '0;
        w[STEP_BIT]                  = p.step;
        w[SEL_LSB +: SEL_W]          = p.sel;
        w[IDX_LSB +: IDX_W]          = p.idx;
        return w;
    endfunction

    function automatic ptr_reg_t ptr_unpack(input logic [DATA_W-1:0] w);
        ptr_reg_t p;
        p.step = w[STEP_BIT];
        p.sel  = w[SEL_LSB +: SEL_W];
        p.idx  = w[IDX_LSB +: IDX_W];
        return p;
    endfunction

endpackage

// File: rtl/ind_tbl_decode.sv
module ind_tbl_decode
    import ind_tbl_pkg::*;
(
    input  ptr_reg_t         ptr,
    output logic             sel_ok,
    output logic             stored,
    output logic [IDX_W-1:0] idx_eff,
    output logic [IDX_W-1:0] idx_next,
    output logic             clipped
);
    logic [IDX_W-1:0] mask;

    always_comb begin
        mask     = idx_mask(ptr.sel);
        sel_ok   = sel_known(ptr.sel);
        stored   = has_store(ptr.sel);
        idx_eff  = ptr.idx & mask;
        idx_next = (idx_eff + IDX_W'(1)) & mask;
        clipped  = sel_ok && ((ptr.idx & ~mask) != '0);
    end
endmodule

// File: rtl/ind_tbl_store.sv
module ind_tbl_store #(
    parameter int DEPTH = 8,
    parameter int W     = 64,
    parameter int IW    = 10,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] a;

    assign a     = AW'(idx);
    assign rdata = mem[a];

    always_ff @(posedge clk) begin
        if (we) mem[a] <= wdata;
    end
endmodule

// File: rtl/ind_tbl_bank.sv
module ind_tbl_bank
    import ind_tbl_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slot_rd [NUM_STORED];

    for (genvar k = 0; k < NUM_STORED; k++) begin : g_slot
        localparam int SEL_K = stored_sel(k);
        localparam int DEP_K = int'(idx_mask(SEL_W'(SEL_K))) + 1;
        logic we_k;
        assign we_k = wr_en && (sel == SEL_W'(SEL_K));
        ind_tbl_store #(.DEPTH(DEP_K), .W(DATA_W), .IW(IDX_W)) u_store (
            .clk   (clk),
            .we    (we_k),
            .idx   (idx),
            .wdata (wdata),
            .rdata (slot_rd[k])
        );
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_STORED; k++) begin
            if (sel == SEL_W'(stored_sel(k))) rdata = slot_rd[k];
        end
    end
endmodule

// File: rtl/ind_table_port.sv
module ind_table_port
    import ind_tbl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_to_data,
    input  logic [63:0]        req_wdata,
    output logic               rsp_valid,
    output logic [63:0]        rsp_rdata,
    output logic [NUM_TBL-1:0] tbl_wstrobe,
    output logic               idx_clip_pulse
);
    ptr_reg_t          ptr_q;
    logic              sel_ok, stored, clipped;
    logic [IDX_W-1:0]  idx_eff, idx_next;
    logic [DATA_W-1:0] bank_rd;
    logic              win_acc, win_wr, ptr_wr, any_rd;

    ind_tbl_decode u_dec (
        .ptr      (ptr_q),
        .sel_ok   (sel_ok),
        .stored   (stored),
        .idx_eff  (idx_eff),
        .idx_next (idx_next),
        .clipped  (clipped)
    );

    assign win_acc = req_valid && req_to_data && sel_ok;
    assign win_wr  = win_acc && req_write;
    assign ptr_wr  = req_valid && !req_to_data && req_write;
    assign any_rd  = req_valid && !req_write;

    ind_tbl_bank u_bank (
        .clk   (clk),
        .wr_en (win_wr && stored),
        .sel   (ptr_q.sel),
        .idx   (idx_eff),
        .wdata (req_wdata),
        .rdata (bank_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q          <= '0;
            rsp_valid      <= 1'b0;
            rsp_rdata      <= '0;
            tbl_wstrobe    <= '0;
            idx_clip_pulse <= 1'b0;
        end else begin
            if (ptr_wr)                     ptr_q     <= ptr_unpack(req_wdata);
            else if (win_acc && ptr_q.step) ptr_q.idx <= idx_next;

            rsp_valid <= any_rd;
            if (any_rd) begin
                if (!req_to_data)           rsp_rdata <= ptr_pack(ptr_q);
                else if (win_acc && stored) rsp_rdata <= bank_rd;
                else                        rsp_rdata <= '0;
            end

            tbl_wstrobe    <= win_wr ? (NUM_TBL'(1) << ptr_q.sel) : '0;
            idx_clip_pulse <= win_acc && clipped;
        end
    end

    // R10
    rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    // R8
    strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
        (tbl_wstrobe != '0) |-> $past(req_valid && req_write && req_to_data));

    // R7
    bad_sel_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_to_data && !sel_known(ptr_q.sel))
        |=> ($stable(ptr_q) && tbl_wstrobe == '0 && !idx_clip_pulse));

    // R4
    step_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_to_data && sel_known(ptr_q.sel) && ptr_q.step)
        |=> ((ptr_q.idx & ~idx_mask(ptr_q.sel)) == '0));

    // R9
    clip_source_chk: assert property (@(posedge clk) disable iff (rst)
        idx_clip_pulse |-> $past(req_valid && req_to_data));
endmodule

// File: tb/ind_table_port_bench.sv
`timescale 1ns/1ps
module ind_table_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_to_data = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic [13:0] tbl_wstrobe;
    logic        idx_clip_pulse;

    always #2 clk = ~clk;

    ind_table_port u_ind_table_port (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_to_data(req_to_data), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .tbl_wstrobe(tbl_wstrobe), .idx_clip_pulse(idx_clip_pulse)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    logic       m_step;
    logic [3:0] m_sel;
    logic [9:0] m_idx;
    logic [63:0] mdl [int];

    function automatic logic [9:0] b_mask(input logic [3:0] s);
        case (s)
            4'd13: return 10'd3;
            4'd11: return 10'd15;
            4'd8:  return 10'd511;
            4'd12, 4'd7, 4'd6: return 10'd255;
            4'd10, 4'd9, 4'd4: return 10'd63;
            4'd3, 4'd2: return 10'd31;
            4'd5, 4'd1, 4'd0: return 10'd7;
            default: return 10'd0;
        endcase
    endfunction

    function automatic bit b_keeps(input logic [3:0] s);
        return (s == 0 || s == 1 || s == 8 || s == 11 || s == 12 || s == 13);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expectation per response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) chk("R10 unexpected response", 64'd1, 64'd0);
            else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
    end

    task automatic ptr_write(input logic st, input logic [3:0] s, input logic [9:0] ix,
                             input logic [63:0] junk);
        logic [63:0] w;
        w = junk & ~64'h0000_0000_800F_03FF;
        w[31] = st; w[19:16] = s; w[9:0] = ix;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_to_data = 0; req_wdata = w;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        m_step = st; m_sel = s; m_idx = ix;
    endtask

    task automatic ptr_read(input string tag);
        logic [63:0] e;
        e = '0; e[31] = m_step; e[19:16] = m_sel; e[9:0] = m_idx;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_to_data = 0;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic win(input bit wr, input logic [63:0] d, input string tag);
        bit known, clip;
        logic [9:0] eff;
        logic [13:0] es;
        int key;
        known = (m_sel < 14);
        eff   = m_idx & b_mask(m_sel);
        clip  = known && (eff != m_idx);
        key   = int'(m_sel) * 1024 + int'(eff);
        es    = (wr && known) ? (14'd1 << m_sel) : 14'd0;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_to_data = 1; req_wdata = d;
        if (!wr) begin
            exp_q.push_back((known && b_keeps(m_sel) && mdl.exists(key)) ? mdl[key] : 64'd0);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        req_valid = 0; req_write = 0;
        chk({tag, " strobe"}, 64'(tbl_wstrobe), 64'(es));
        chk({tag, " clip"}, 64'(idx_clip_pulse), 64'(clip));
        if (wr && known && b_keeps(m_sel)) mdl[key] = d;
        if (known && m_step) m_idx = (eff + 10'd1) & b_mask(m_sel);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog: actual hung, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        m_step = 0; m_sel = 0; m_idx = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        chk("R11 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R11 strobe", 64'(tbl_wstrobe), 64'd0);
        chk("R11 clip", 64'(idx_clip_pulse), 64'd0);
        ptr_read("R11 pointer");

        // R1 field isolation
        ptr_write(1, 4'd8, 10'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        ptr_read("R1 fields only");

        // R5 / R8 / R4 stream into table 8
        for (int i = 0; i < 4; i++) win(1, 64'hA5A5_0000_0000_0000 + 64'(i), "R8 R5 stream write");
        ptr_read("R4 step after writes");
        ptr_write(1, 4'd8, 10'd0, '0);
        for (int i = 0; i < 4; i++) win(0, '0, "R5 stream read");
        ptr_read("R4 step after reads");

        // R4 wrap inside table 13, R9 / R3 aliasing
        ptr_write(1, 4'd13, 10'd2, '0);
        win(1, 64'h1111, "R4 wrap write");
        win(1, 64'h2222, "R4 wrap write");
        ptr_read("R4 wrapped to zero");
        ptr_write(0, 4'd13, 10'd6, '0);
        win(1, 64'h3333, "R9 R3 clipped write");
        ptr_write(0, 4'd13, 10'd2, '0);
        win(0, '0, "R3 alias read");
        ptr_read("R4 no step");

        // R6 storage-less table 5
        ptr_write(1, 4'd5, 10'd7, '0);
        win(1, 64'hDEAD, "R6 R8 discard write");
        ptr_write(1, 4'd5, 10'd7, '0);
        win(0, '0, "R6 zero read");
        ptr_read("R6 R4 step wraps");

        // R7 unknown selects
        for (int s = 14; s < 16; s++) begin
            ptr_write(1, 4'(s), 10'd3, '0);
            win(1, 64'hBEEF, "R7 inert write");
            win(0, '0, "R7 zero read");
            ptr_read("R7 pointer kept");
        end

        // R2 per-table masks: entry 1023 folds to the mask, step wraps to 0
        for (int s = 0; s < 14; s++) begin
            ptr_write(1, 4'(s), 10'd1023, '0);
            win(1, 64'hC0DE_0000 + 64'(s), "R2 R9 top entry write");
            ptr_read("R2 wrap to zero");
            ptr_write(0, 4'(s), b_mask(4'(s)), '0);
            win(0, '0, "R2 R5 R6 top entry read");
        end

        // other kept tables
        ptr_write(1, 4'd0, 10'd0, '0);
        win(1, 64'h0101, "R5 table 0");
        ptr_write(1, 4'd11, 10'd5, '0);
        win(1, 64'h0B0B, "R5 table 11");
        ptr_write(0, 4'd0, 10'd8, '0);
        win(0, '0, "R3 R5 alias table 0");
        ptr_write(0, 4'd11, 10'd5, '0);
        win(0, '0, "R5 table 11 read");

        repeat (3) @(negedge clk);
        chk("R10 all responses seen", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule